// File: doc/BRIEF.md
# Autovectored Interrupt Entry Sequencer

This block carries a 16/32-bit processor through the entry into an autovectored external interrupt. It watches a 3-bit pending interrupt level against the mask field of the current status word. When a level is allowed in, it latches the status word, the return address and the stack pointer that applies, and then runs a fixed, cycle-exact sequence on a 16-bit word bus:
- It moves to the supervisor stack and reserves a six-byte frame.
- It writes the old status word.
- It spends an acknowledge window whose length depends on the phase of a slow divide-by-ten peripheral clock.
- It raises privilege and the mask.
- It stacks the return address, low word first.
- It fetches the handler address from the autovector table.

After a fixed tail of cycles it pulses `done` with the handler address. The surrounding core picks up the new program counter, status word and supervisor stack pointer from the result ports at that pulse.

The bus side is a plain master. `bus_req` stays high for the whole of an access. A word access lasts at least four cycles and is stretched while `bus_rdy` is low. Read data is taken in the cycle the access ends.

Top module: `irq_entry_seq`

## Requirements
- R1: A level on `irq_lvl` is accepted at a clock edge, while the block is idle, when it is nonzero and either exceeds `sr_in[10:8]` or equals 7. `busy` is high from the next cycle until the cycle after the `done` pulse.
- R2: The frame base is `ssp_in` when `sr_in[13]` is 0 (user mode) and `a7_in` when it is 1 (supervisor mode). The stack pointer drops by 6 in one step, and the result is reported on `new_ssp`.
- R3: The bus stays idle for exactly 6 cycles after the accept edge. The SR write request is first high in the 7th cycle after the cycle in which the level was presented. It writes the original status word to address `new_ssp`.
- R4: After the SR write ends, the acknowledge window lasts 9 cycles plus the E phase sampled at the SR write's completing edge, and 4 idle cycles follow it. The next request rises 14 + phase cycles after the SR write's last cycle.
- R5: The final status word keeps bits 15:14, 12:11 and 7:0, sets bit 13, and puts the accepted level in bits 10:8.
- R6: The return address is written after the acknowledge: first its low 16 bits to `new_ssp`+4, then its high 16 bits to `new_ssp`+2, back to back.
- R7: One cycle after the second return-address write, `iack_stb` pulses for one cycle with the level on `iack_lvl`. Two reads then fetch the new PC: the high word from 0x60 + 4 × level, then the low word from that address + 2.
- R8: `done` is a one-cycle pulse in the 11th cycle after the last cycle of the vector low-word read. `new_pc`, `new_sr` and `new_ssp` are valid while it is high.
- R9: Every bus access holds `bus_req` for at least 4 cycles. `bus_rdy` is ignored in the first 3 of them, and each cycle `bus_rdy` is low from the 4th cycle on adds one cycle.
- R10: A nonzero level that is not accepted raises `irq_wait`, leaves `busy` low and starts no bus access. A level of 0 keeps `irq_wait` low.
- R11: Changes on `irq_lvl`, `sr_in`, `pc_in`, `a7_in` and `ssp_in` while `busy` is high do not affect the frame contents, the vector, or the results.
- R12: The E phase is a free-running count 0..9. It is 0 during reset and advances by one at every clock edge after reset release, wrapping after 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| irq_lvl | input | 3 | Pending interrupt level, 0 = none |
| sr_in | input | 16 | Current status word (bit 13 supervisor, bits 10:8 mask) |
| a7_in | input | AW | Active stack pointer (the supervisor one when bit 13 is set) |
| ssp_in | input | AW | Supervisor stack pointer held aside in user mode |
| pc_in | input | 32 | Return address to stack |
| bus_req | output | 1 | Bus access in progress |
| bus_we | output | 1 | 1 = word write, 0 = word read |
| bus_addr | output | AW | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken in the last cycle of a read |
| bus_rdy | input | 1 | Slave ready; ends an access from its 4th cycle on |
| iack_stb | output | 1 | One-cycle strobe when the vector address is formed |
| iack_lvl | output | 3 | Accepted level during `iack_stb`, else 0 |
| irq_wait | output | 1 | A nonzero level is present but masked |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address read from the vector table |
| new_sr | output | 16 | Status word after the update |
| new_ssp | output | AW | Supervisor stack pointer after the frame is reserved |

## Verification
The bench aims at the E-phase-dependent acknowledge length. It starts interrupts at staggered offsets so the sampled phase takes many values, including 0 and 9. A design that sampled the phase one edge off, or left out the four trailing idle cycles, would move the first return-address write by a cycle or more. The bench also runs the two masking corners, level equal to the mask and level 7 against mask 7. A wrong comparison there either starts the bus or leaves a non-maskable request pending. Further targets are the stack word order and address, where a swapped or misplaced word reaches the scoreboard with the wrong address or data, and wait states combined with a ready that is high early. A timer that ended on the early ready would shorten the access below four cycles.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_WSR,
    ST_ACK,
    ST_POST,
    ST_WPCL,
    ST_WPCH,
    ST_VEC,
    ST_RDH,
    ST_RDL,
    ST_TAIL,
    ST_DONE
  } seq_st_e;

  // Acceptance rule: nonzero and above the mask, or the unmaskable level 7.
  function automatic logic level_passes(input logic [2:0] lvl, input logic [2:0] mask);
    return (lvl != 3'd0) && ((lvl > mask) || (lvl == 3'd7));
  endfunction

endpackage

// File: rtl/irq_eclk_phase.sv
module irq_eclk_phase #(
  parameter int DIV = 10,
  parameter int PW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_n;

  always_comb begin
    if (phase == LAST) phase_n = '0;
    else               phase_n = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_n;
  end

  // R12: the phase stays inside 0..DIV-1 and wraps to 0 after the last value
  assert_phase_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST) else $error("phase out of range");
  assert_phase_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == '0)) else $error("phase did not wrap");

endmodule

// File: rtl/irq_bus_timer.sv
module irq_bus_timer #(
  parameter int MIN_CYC = 4,
  parameter int CW      = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rdy,
  output logic fin
);

  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt, cnt_n;

  // An access may end only once it has lasted MIN_CYC cycles and the slave is ready.
  assign fin = req && rdy && (cnt == LAST);

  always_comb begin
    if (!req || fin)      cnt_n = '0;
    else if (cnt == LAST) cnt_n = cnt;
    else                  cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R9: once raised, a request is kept until the access has ended
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fin) |=> req) else $error("request dropped mid-access");
  // R9: an access that has just started cannot end in its first cycle
  assert_min_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !fin) else $error("access ended too early");

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int VEC_BASE  = 96,
  parameter int E_DIV     = 10,
  parameter int ACK_BASE  = 9,
  parameter int PRE_IDLE  = 6,
  parameter int POST_IDLE = 4,
  parameter int TAIL_CYC  = 10,
  parameter int BUS_MIN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    irq_lvl,
  input  logic [15:0]   sr_in,
  input  logic [AW-1:0] a7_in,
  input  logic [AW-1:0] ssp_in,
  input  logic [31:0]   pc_in,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_rdy,
  output logic          iack_stb,
  output logic [2:0]    iack_lvl,
  output logic          irq_wait,
  output logic          busy,
  output logic          done,
  output logic [31:0]   new_pc,
  output logic [15:0]   new_sr,
  output logic [AW-1:0] new_ssp
);

  localparam int PW       = $clog2(E_DIV);
  localparam int ACK_MAX  = ACK_BASE + E_DIV - 1;
  localparam int M1       = (ACK_MAX > PRE_IDLE) ? ACK_MAX : PRE_IDLE;
  localparam int M2       = (POST_IDLE > TAIL_CYC) ? POST_IDLE : TAIL_CYC;
  localparam int WMAX     = (M1 > M2) ? M1 : M2;
  localparam int WCW      = $clog2(WMAX + 1);
  localparam int FRAME_B  = 6;

  seq_st_e        st, st_n;
  logic [WCW-1:0] wcnt, wcnt_n;
  logic [2:0]     lvl_q;
  logic [15:0]    sr_q, sr_new_q;
  logic [AW-1:0]  sp_q;
  logic [31:0]    pc_q;
  logic [15:0]    vhi_q, vlo_q;
  logic           cap_en, sr_upd_en, vhi_en, vlo_en;
  logic           accept, fin;
  logic [PW-1:0]  e_phase;
  logic [AW-1:0]  vec_addr;

  irq_eclk_phase #(.DIV(E_DIV)) u_eclk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (e_phase)
  );

  irq_bus_timer #(.MIN_CYC(BUS_MIN)) u_btmr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .rdy   (bus_rdy),
    .fin   (fin)
  );

  assign accept   = (st == ST_IDLE) && level_passes(irq_lvl, sr_in[10:8]);
  assign vec_addr = AW'(VEC_BASE) + AW'({lvl_q, 2'b00});

  // Next-state logic
  always_comb begin
    st_n      = st;
    wcnt_n    = wcnt;
    cap_en    = 1'b0;
    sr_upd_en = 1'b0;
    vhi_en    = 1'b0;
    vlo_en    = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        st_n   = ST_PRE;
        wcnt_n = WCW'(PRE_IDLE - 1);
        cap_en = 1'b1;
      end
      ST_PRE: begin
        if (wcnt == '0) st_n = ST_WSR;
        else            wcnt_n = wcnt - 1'b1;
      end
      ST_WSR: if (fin) begin
        st_n   = ST_ACK;
        wcnt_n = WCW'(ACK_BASE - 1) + WCW'(e_phase);
      end
      ST_ACK: begin
        if (wcnt == '0) begin
          st_n   = ST_POST;
          wcnt_n = WCW'(POST_IDLE - 1);
        end else begin
          wcnt_n = wcnt - 1'b1;
        end
      end
      ST_POST: begin
        if (wcnt == '0) begin
          st_n      = ST_WPCL;
          sr_upd_en = 1'b1;
        end else begin
          wcnt_n = wcnt - 1'b1;
        end
      end
      ST_WPCL: if (fin) st_n = ST_WPCH;
      ST_WPCH: if (fin) st_n = ST_VEC;
      ST_VEC:  st_n = ST_RDH;
      ST_RDH: if (fin) begin
        st_n   = ST_RDL;
        vhi_en = 1'b1;
      end
      ST_RDL: if (fin) begin
        st_n   = ST_TAIL;
        wcnt_n = WCW'(TAIL_CYC - 1);
        vlo_en = 1'b1;
      end
      ST_TAIL: begin
        if (wcnt == '0) st_n = ST_DONE;
        else            wcnt_n = wcnt - 1'b1;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wcnt <= '0;
    end else begin
      st   <= st_n;
      wcnt <= wcnt_n;
    end
  end

  // Context captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      sr_q  <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
    end else if (cap_en) begin
      lvl_q <= irq_lvl;
      sr_q  <= sr_in;
      pc_q  <= pc_in;
      sp_q  <= (sr_in[13] ? a7_in : ssp_in) - AW'(FRAME_B);
    end
  end

  // Status word update after the acknowledge window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr_new_q <= '0;
    else if (sr_upd_en) sr_new_q <= {sr_q[15:14], 1'b1, sr_q[12:11], lvl_q, sr_q[7:0]};
  end

  // Vector words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vhi_q <= '0;
    else if (vhi_en) vhi_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vlo_q <= '0;
    else if (vlo_en) vlo_q <= bus_rdata;
  end

  // Bus drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st)
      ST_WSR: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q; bus_wdata = sr_q;
      end
      ST_WPCL: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q + AW'(4); bus_wdata = pc_q[15:0];
      end
      ST_WPCH: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q + AW'(2); bus_wdata = pc_q[31:16];
      end
      ST_RDH: begin
        bus_req = 1'b1; bus_addr = vec_addr;
      end
      ST_RDL: begin
        bus_req = 1'b1; bus_addr = vec_addr + AW'(2);
      end
      default: ;
    endcase
  end

  assign iack_stb = (st == ST_VEC);
  assign iack_lvl = (st == ST_VEC) ? lvl_q : 3'd0;
  assign irq_wait = (st == ST_IDLE) && (irq_lvl != 3'd0) && !accept;
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign new_pc   = {vhi_q, vlo_q};
  assign new_sr   = sr_new_q;
  assign new_ssp  = sp_q;

  // R1: a sequence only starts from a level that passed the mask test
  assert_accept_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (($past(irq_lvl) > $past(sr_in[10:8])) || ($past(irq_lvl) == 3'd7)))
    else $error("sequence started from a masked level");
  // R2: the frame pointer does not move once the sequence is running
  assert_ssp_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(new_ssp)) else $error("stack pointer moved");
  // R5: at the acknowledge strobe, privilege is set and the mask holds the level
  assert_sr_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iack_stb |-> (new_sr[13] && (new_sr[10:8] == iack_lvl))) else $error("status word not updated");
  // R7: the strobe lasts one cycle and is followed by the vector read
  assert_iack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iack_stb |=> (!iack_stb && bus_req && !bus_we)) else $error("strobe shape");
  // R8: done is a single-cycle pulse that returns to idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)) else $error("done not a pulse");
  // R10: a pending-but-masked indication never coincides with activity
  assert_wait_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wait |-> (!busy && !bus_req)) else $error("wait flag while active");

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  localparam int AW = 32;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [15:0]   data;
  } bus_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    irq_lvl;
  logic [15:0]   sr_in;
  logic [AW-1:0] a7_in, ssp_in;
  logic [31:0]   pc_in;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic          bus_rdy;
  logic          iack_stb;
  logic [2:0]    iack_lvl;
  logic          irq_wait, busy, done;
  logic [31:0]   new_pc;
  logic [15:0]   new_sr;
  logic [AW-1:0] new_ssp;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int wait_n = 0;
  int reqcyc = 0;
  int tix = 0;
  int start_cyc [5];
  int end_cyc [5];
  int done_cyc;
  int iack_cyc;
  logic [2:0] iack_seen;
  bit done_seen;
  bus_item_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .sr_in(sr_in),
    .a7_in(a7_in), .ssp_in(ssp_in), .pc_in(pc_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .iack_stb(iack_stb), .iack_lvl(iack_lvl), .irq_wait(irq_wait),
    .busy(busy), .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_ssp(new_ssp)
  );

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return 16'h4E71 ^ (a[15:0] * 16'd37) ^ a[31:16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) cyc++;
    end
  end

  // Bus slave and scoreboard monitor
  initial begin
    bus_rdy   = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        if (reqcyc == 0 && tix < 5) start_cyc[tix] = cyc;
        reqcyc++;
        bus_rdy   = (wait_n == 0) || (reqcyc >= 4 + wait_n);
        bus_rdata = bus_we ? 16'h0 : mem_word(bus_addr);
        if (bus_rdy && reqcyc >= 4) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected bus access", bus_addr, 32'h0);
          end else begin
            bus_item_t e;
            string tag;
            e = exp_q.pop_front();
            tag = (tix == 0) ? "R3 SR write" : ((tix < 3) ? "R6 PC write" : "R7 vector read");
            chk(bus_addr == e.addr, {tag, " address"}, bus_addr, e.addr);
            chk(bus_we == e.we, {tag, " direction"}, {31'h0, bus_we}, {31'h0, e.we});
            if (e.we) chk(bus_wdata == e.data, {tag, " data"}, {16'h0, bus_wdata}, {16'h0, e.data});
            chk(reqcyc == 4 + wait_n, "R9 access length", reqcyc, 4 + wait_n);
          end
          if (tix < 5) end_cyc[tix] = cyc;
          tix++;
          reqcyc = 0;
        end
      end else begin
        reqcyc  = 0;
        bus_rdy = 1'b0;
      end
      if (iack_stb) begin
        iack_seen = iack_lvl;
        iack_cyc  = cyc;
      end
      if (done) begin
        done_cyc  = cyc;
        done_seen = 1'b1;
      end
    end
  end

  task automatic run_irq(input logic [2:0] lvl, input logic [15:0] sr, input logic [31:0] a7,
                         input logic [31:0] ssp, input logic [31:0] pc, input int waits);
    logic [31:0] base, sp, vec, exp_pc;
    logic [15:0] exp_sr;
    int d, ph;
    base   = sr[13] ? a7 : ssp;
    sp     = base - 32'd6;
    vec    = 32'h60 + {27'h0, lvl, 2'b00};
    exp_pc = {mem_word(vec), mem_word(vec + 32'd2)};
    exp_sr = (sr & 16'hD8FF) | 16'h2000 | {5'h0, lvl, 8'h0};
    wait_n = waits;
    tix = 0;
    done_seen = 1'b0;
    iack_seen = 3'd0;
    exp_q.push_back('{1'b1, sp, sr});
    exp_q.push_back('{1'b1, sp + 32'd4, pc[15:0]});
    exp_q.push_back('{1'b1, sp + 32'd2, pc[31:16]});
    exp_q.push_back('{1'b0, vec, 16'h0});
    exp_q.push_back('{1'b0, vec + 32'd2, 16'h0});
    @(negedge clk);
    irq_lvl = lvl; sr_in = sr; a7_in = a7; ssp_in = ssp; pc_in = pc;
    d = cyc;
    @(negedge clk);
    chk(busy == 1'b1, "R1 accept raises busy", {31'h0, busy}, 32'h1);
    // R11: disturb every captured input while the sequence runs
    irq_lvl = 3'd7; sr_in = ~sr; a7_in = a7 ^ 32'h0F0F_0F00; ssp_in = ssp + 32'h100; pc_in = ~pc;
    wait (done_seen);
    @(negedge clk);
    irq_lvl = 3'd0;
    chk(start_cyc[0] - d == 7, "R3 idle gap before SR write", start_cyc[0] - d, 7);
    ph = end_cyc[0] % 10;
    chk(start_cyc[1] - end_cyc[0] == 14 + ph, "R4 ack window length", start_cyc[1] - end_cyc[0], 14 + ph);
    chk(start_cyc[2] - end_cyc[1] == 1, "R6 PC words back to back", start_cyc[2] - end_cyc[1], 1);
    chk(iack_cyc - end_cyc[2] == 1 && iack_seen == lvl, "R7 ack level strobe", {29'h0, iack_seen}, {29'h0, lvl});
    chk(start_cyc[3] - iack_cyc == 1, "R7 vector read follows strobe", start_cyc[3] - iack_cyc, 1);
    chk(done_cyc - end_cyc[4] == 11, "R8 done timing", done_cyc - end_cyc[4], 11);
    chk(new_pc == exp_pc, "R7 R11 new PC", new_pc, exp_pc);
    chk(new_sr == exp_sr, "R5 R11 new SR", {16'h0, new_sr}, {16'h0, exp_sr});
    chk(new_ssp == sp, "R2 R11 new SSP", new_ssp, sp);
    chk(tix == 5 && exp_q.size() == 0, "R6 access count", tix, 5);
    chk(busy == 1'b0 && done == 1'b0, "R1 R8 back to idle", {30'h0, busy, done}, 32'h0);
    exp_q.delete();
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_lvl = 3'd0; sr_in = 16'h0700; a7_in = '0; ssp_in = '0; pc_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && !iack_stb && new_pc == 32'h0, "R1 reset state",
        {28'h0, busy, done, bus_req, iack_stb}, 32'h0);
    rst_n = 1'b1;

    // R10: masked levels stay pending, no activity
    sr_in = 16'h0500; irq_lvl = 3'd3;
    repeat (12) begin
      @(negedge clk);
      chk(irq_wait && !busy && !bus_req, "R10 level below mask held", {29'h0, irq_wait, busy, bus_req}, 32'h4);
    end
    irq_lvl = 3'd5;
    @(negedge clk);
    chk(irq_wait && !busy, "R10 level equal to mask held", {30'h0, irq_wait, busy}, 32'h2);
    irq_lvl = 3'd0;
    @(negedge clk);
    chk(!irq_wait && !busy, "R10 zero level not pending", {30'h0, irq_wait, busy}, 32'h0);

    // User mode, frame on ssp_in, no waits
    run_irq(3'd6, 16'h0215, 32'h0000_8000, 32'h00FF_F000, 32'h0012_3456, 0);
    // Supervisor mode, level 7 against mask 7, trace bit kept, waits
    run_irq(3'd7, 16'hA71F, 32'h0001_2340, 32'h0077_0000, 32'hDEAD_BEE0, 2);
    // Phase sweep: staggered start offsets
    for (int i = 0; i < 12; i++) begin
      repeat (i) @(negedge clk);
      run_irq(3'((i % 7) + 1), (i % 2 == 0) ? 16'h0000 : 16'h2004, 32'h0004_0000 + 32'(i * 64),
              32'h0010_0000 - 32'(i * 16), 32'hC000_0000 + 32'(i * 258), i % 4);
    end

    // R12: phase keeps counting after reset release; checked through R4 above
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule